// File: doc/BRIEF.md
# Single-Channel Peripheral-to-Memory DMA Engine

This block moves a programmed number of data items from one peripheral to memory. When it is started from idle, it captures a full channel setup. That setup picks one of several request lines, sets the address stepping rules for each side, the FIFO drain level, the FIFO or pass-through path, the acknowledge style and a priority code. The engine then serves the chosen requester one item at a time. Each item is taken over a valid/ready read port, held in a small FIFO and written to memory over a valid/ready write port, in bursts set by the chosen fill level. When the last item has been written, the engine pulses an interrupt and goes back to idle.

Both data ports follow the usual valid/ready rule: an item moves on a rising edge where valid and ready are both high. On the read side, `pv_ready_o` is raised for one cycle per item, and only while the acknowledge is high. Once the engine raises `mw_valid_o`, it keeps it high, and keeps the address and data unchanged, until `mw_ready_i` accepts the item. The memory side may stall the engine for any number of cycles. Choosing between several channels is left to an arbiter outside the block. The block only offers that arbiter its priority code.

Top module: `dma_chan`

## Requirements
- R1: A start pulse seen while idle with a non-zero count captures every `cfg_*` input. A start with a count of zero leaves the engine idle. While a transfer runs, changes to `cfg_*` and further start pulses have no effect.
- R2: Only request line `req_i[cfg_sel_i]` can open a handshake. Activity on the other lines leaves `ack_o` low.
- R3: With `cfg_pinc_i`=0 every read uses the base peripheral address. With `cfg_pinc_i`=1 the address advances after each item, by P_BYTES (default 2) when `cfg_pfix4_i`=0 and by 4 when `cfg_pfix4_i`=1.
- R4: With `cfg_minc_i`=0 every write uses the base memory address. With `cfg_minc_i`=1 it advances by DW/8 (default 4) after each written item.
- R5: `prio_o` carries the captured 2-bit priority code while a transfer runs (0 low, 1 medium, 2 high, 3 very high) and reads 0 while idle.
- R6: In FIFO mode the first memory write of a burst waits until the FIFO holds (DEPTH/4)·(thr+1) items, where thr is `cfg_thr_i`. With DEPTH=8 this gives 2, 4, 6 or 8 items for codes 0 to 3.
- R7: With `cfg_direct_i`=1 each item read is written to memory before the next read begins, and no fill level is waited for.
- R8: With `cfg_altack_i`=0, once `ack_o` is up it stays high until the item has been taken and the selected request line has also dropped.
- R9: With `cfg_altack_i`=1, `ack_o` drops the cycle after the item is taken, even if the request line is still high.
- R10: Items left in the FIFO below the drain level after the last read are still written to memory, so exactly count items reach memory, in the order they were read.
- R11: `irq_o` is high for exactly one cycle, on the edge that accepts the last memory write, and the engine is idle from that point.
- R12: `pv_ready_o` is high only while `ack_o` is high. While `mw_valid_o` is high and `mw_ready_i` is low, `mw_valid_o`, `mw_addr_o` and `mw_data_o` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; taken only while idle |
| cfg_sel_i | input | SELW (3) | Index of the request line to serve |
| cfg_pinc_i | input | 1 | Peripheral address increment enable |
| cfg_minc_i | input | 1 | Memory address increment enable |
| cfg_pfix4_i | input | 1 | Peripheral step forced to 4 bytes |
| cfg_prio_i | input | 2 | Priority code for the arbiter |
| cfg_thr_i | input | 2 | FIFO drain level code |
| cfg_direct_i | input | 1 | Pass-through mode, FIFO level ignored |
| cfg_altack_i | input | 1 | Acknowledge drops on completion alone |
| cfg_count_i | input | CW (16) | Number of items to move |
| cfg_pbase_i | input | AW (32) | Peripheral base address |
| cfg_mbase_i | input | AW (32) | Memory base address |
| req_i | input | NREQ (8) | Peripheral request lines |
| ack_o | output | 1 | Acknowledge to the selected requester |
| prio_o | output | 2 | Priority code toward the arbiter |
| irq_o | output | 1 | One-cycle completion pulse |
| pv_addr_o | output | AW (32) | Address of the current peripheral read |
| pv_valid_i | input | 1 | Peripheral data valid |
| pv_ready_o | output | 1 | Engine ready to take peripheral data |
| pv_data_i | input | DW (32) | Peripheral data |
| mw_valid_o | output | 1 | Memory write valid |
| mw_ready_i | input | 1 | Memory write ready |
| mw_addr_o | output | AW (32) | Memory write address |
| mw_data_o | output | DW (32) | Memory write data |

## Verification
Every output comes from a register, so cycle timing is known exactly. A request seen at one edge shows `ack_o` and `pv_ready_o` at the next edge. The item is then taken on the edge after that. An item that completes the drain level shows `mw_valid_o` one edge after its push, and `irq_o` rises on the edge that accepts the last write. The bench changes inputs and reads outputs on the falling edge. A monitor logs every handshake at the falling edge just before the rising edge where it completes, so fill counts, addresses and data are compared with what the requirements predict at that point. For the acknowledge and request-select cases, the checks wait the exact one or two falling edges the registered state machine needs.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_XFER = 2'd1,
    HS_HOLD = 2'd2
  } hs_state_e;

  typedef struct packed {
    logic       pinc;
    logic       minc;
    logic       pfix4;
    logic [1:0] prio;
    logic [1:0] thr;
    logic       direct;
    logic       altack;
  } chan_cfg_t;

endpackage

// File: rtl/dma_chan_fifo.sv
module dma_chan_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [DW-1:0]              din,
  input  logic                       pop,
  output logic [DW-1:0]              dout,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int PW = $clog2(DEPTH);

  logic [DW-1:0] store [DEPTH];
  logic [PW-1:0] wp, rp;

  always_ff @(posedge clk) begin
    if (push) store[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assign dout = store[rp];
endmodule

// File: rtl/dma_chan_agen.sv
module dma_chan_agen #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic          adv,
  input  logic          en,
  input  logic [AW-1:0] step,
  output logic [AW-1:0] addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         addr <= '0;
    else if (load)      addr <= base;
    else if (adv && en) addr <= addr + step;
  end
endmodule

// File: rtl/dma_chan_hs.sv
module dma_chan_hs
  import dma_chan_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic req,
  input  logic fire,
  input  logic alt,
  output logic ack,
  output logic ready
);
  hs_state_e st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= HS_IDLE;
    else begin
      unique case (st)
        HS_IDLE: if (go) st <= HS_XFER;
        HS_XFER: if (fire) st <= (!alt && req) ? HS_HOLD : HS_IDLE;
        HS_HOLD: if (!req) st <= HS_IDLE;
        default: st <= HS_IDLE;
      endcase
    end
  end

  assign ack   = (st == HS_XFER) || (st == HS_HOLD);
  assign ready = (st == HS_XFER);
endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_chan_pkg::*;
#(
  parameter int DW      = 32,
  parameter int AW      = 32,
  parameter int CW      = 16,
  parameter int DEPTH   = 8,
  parameter int NREQ    = 8,
  parameter int P_BYTES = 2,
  localparam int SELW   = $clog2(NREQ)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [SELW-1:0] cfg_sel_i,
  input  logic            cfg_pinc_i,
  input  logic            cfg_minc_i,
  input  logic            cfg_pfix4_i,
  input  logic [1:0]      cfg_prio_i,
  input  logic [1:0]      cfg_thr_i,
  input  logic            cfg_direct_i,
  input  logic            cfg_altack_i,
  input  logic [CW-1:0]   cfg_count_i,
  input  logic [AW-1:0]   cfg_pbase_i,
  input  logic [AW-1:0]   cfg_mbase_i,
  input  logic [NREQ-1:0] req_i,
  output logic            ack_o,
  output logic [1:0]      prio_o,
  output logic            irq_o,
  output logic [AW-1:0]   pv_addr_o,
  input  logic            pv_valid_i,
  output logic            pv_ready_o,
  input  logic [DW-1:0]   pv_data_i,
  output logic            mw_valid_o,
  input  logic            mw_ready_i,
  output logic [AW-1:0]   mw_addr_o,
  output logic [DW-1:0]   mw_data_o
);
  localparam int FCW = $clog2(DEPTH + 1);
  localparam logic [FCW-1:0] QTR   = FCW'(DEPTH / 4);
  localparam logic [FCW-1:0] FULL  = FCW'(DEPTH);
  localparam logic [AW-1:0]  PSTEP = AW'(P_BYTES);
  localparam logic [AW-1:0]  MSTEP = AW'(DW / 8);

  chan_cfg_t       cfg_q;
  logic [SELW-1:0] sel_q;
  logic            busy_q, mb_q, irq_q;
  logic [CW-1:0]   remain_q, fetch_q;
  logic [FCW-1:0]  blen_q;
  logic [FCW-1:0]  fifo_level;
  logic [FCW-1:0]  thr_lvl, burst_len;
  logic            accept, req_sel, space, go, p_fire, m_fire, start_burst, hit_lvl;

  assign accept  = !busy_q && start_i && (cfg_count_i != '0);
  assign req_sel = req_i[sel_q];
  assign p_fire  = pv_valid_i && pv_ready_o;
  assign m_fire  = mw_valid_o && mw_ready_i;
  assign thr_lvl = QTR * ({{(FCW-2){1'b0}}, cfg_q.thr} + FCW'(1));
  assign space   = cfg_q.direct ? (fifo_level == '0) : (fifo_level < FULL);
  assign go      = busy_q && (fetch_q != '0) && space && req_sel;

  // Direct mode drains every single item; FIFO mode waits for the level
  // unless the peripheral side has nothing more to deliver (flush).
  assign hit_lvl     = cfg_q.direct ? 1'b1 : (fifo_level >= thr_lvl);
  assign start_burst = busy_q && !mb_q && (fifo_level != '0) && (hit_lvl || fetch_q == '0);
  assign burst_len   = cfg_q.direct ? FCW'(1) :
                       ((fifo_level >= thr_lvl) ? thr_lvl : fifo_level);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      sel_q    <= '0;
      busy_q   <= 1'b0;
      mb_q     <= 1'b0;
      irq_q    <= 1'b0;
      remain_q <= '0;
      fetch_q  <= '0;
      blen_q   <= '0;
    end else begin
      irq_q <= 1'b0;
      if (accept) begin
        busy_q   <= 1'b1;
        sel_q    <= cfg_sel_i;
        remain_q <= cfg_count_i;
        fetch_q  <= cfg_count_i;
        cfg_q    <= '{pinc: cfg_pinc_i, minc: cfg_minc_i, pfix4: cfg_pfix4_i,
                      prio: cfg_prio_i, thr: cfg_thr_i, direct: cfg_direct_i,
                      altack: cfg_altack_i};
      end else if (busy_q) begin
        if (p_fire) fetch_q <= fetch_q - CW'(1);
        if (start_burst) begin
          mb_q   <= 1'b1;
          blen_q <= burst_len;
        end else if (m_fire) begin
          remain_q <= remain_q - CW'(1);
          blen_q   <= blen_q - FCW'(1);
          if (blen_q == FCW'(1)) mb_q <= 1'b0;
          if (remain_q == CW'(1)) begin
            busy_q <= 1'b0;
            mb_q   <= 1'b0;
            irq_q  <= 1'b1;
          end
        end
      end
    end
  end

  dma_chan_hs u_hs (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (go),
    .req   (req_sel),
    .fire  (p_fire),
    .alt   (cfg_q.altack),
    .ack   (ack_o),
    .ready (pv_ready_o)
  );

  dma_chan_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (p_fire),
    .din   (pv_data_i),
    .pop   (m_fire),
    .dout  (mw_data_o),
    .level (fifo_level)
  );

  dma_chan_agen #(.AW(AW)) u_pgen (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .base  (cfg_pbase_i),
    .adv   (p_fire),
    .en    (cfg_q.pinc),
    .step  (cfg_q.pfix4 ? AW'(4) : PSTEP),
    .addr  (pv_addr_o)
  );

  dma_chan_agen #(.AW(AW)) u_mgen (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .base  (cfg_mbase_i),
    .adv   (m_fire),
    .en    (cfg_q.minc),
    .step  (MSTEP),
    .addr  (mw_addr_o)
  );

  assign mw_valid_o = mb_q;
  assign irq_o      = irq_q;
  assign prio_o     = busy_q ? cfg_q.prio : 2'd0;
endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk #(
  parameter int DW    = 32,
  parameter int AW    = 32,
  parameter int DEPTH = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       pv_valid,
  input logic                       pv_ready,
  input logic                       ack,
  input logic                       mw_valid,
  input logic                       mw_ready,
  input logic [AW-1:0]              mw_addr,
  input logic [DW-1:0]              mw_data,
  input logic                       irq,
  input logic                       busy,
  input logic                       alt,
  input logic                       direct,
  input logic                       req_sel,
  input logic [$clog2(DEPTH+1)-1:0] level
);
  a_r12_ready_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
    pv_ready |-> ack);

  a_r12_write_held: assert property (@(posedge clk) disable iff (!rst_n)
    mw_valid && !mw_ready |=> mw_valid && $stable(mw_addr) && $stable(mw_data));

  a_r11_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r11_idle_at_irq: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !busy);

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    level <= ($clog2(DEPTH+1))'(DEPTH));

  a_r7_direct_one_item: assert property (@(posedge clk) disable iff (!rst_n)
    busy && direct |-> level <= ($clog2(DEPTH+1))'(1));

  a_r8_ack_waits_req: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack) && !alt |-> !$past(req_sel));

  a_r9_alt_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pv_valid && pv_ready) && alt |-> !ack);
endmodule

bind dma_chan dma_chan_chk #(.DW(DW), .AW(AW), .DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pv_valid (pv_valid_i),
  .pv_ready (pv_ready_o),
  .ack      (ack_o),
  .mw_valid (mw_valid_o),
  .mw_ready (mw_ready_i),
  .mw_addr  (mw_addr_o),
  .mw_data  (mw_data_o),
  .irq      (irq_o),
  .busy     (busy_q),
  .alt      (cfg_q.altack),
  .direct   (cfg_q.direct),
  .req_sel  (req_sel),
  .level    (fifo_level)
);

// File: tb/dma_chan_tb.sv
`timescale 1ns/1ps
module dma_chan_tb;
  localparam int DW = 32, AW = 32, CW = 16, NREQ = 8;
  localparam logic [DW-1:0] DBASE = 32'hA000_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic            start_i = 0;
  logic [2:0]      cfg_sel = 0;
  logic            cfg_pinc = 0, cfg_minc = 0, cfg_pfix4 = 0, cfg_direct = 0, cfg_alt = 0;
  logic [1:0]      cfg_prio = 0, cfg_thr = 0;
  logic [CW-1:0]   cfg_count = 0;
  logic [AW-1:0]   cfg_pbase = 0, cfg_mbase = 0;
  logic [NREQ-1:0] req_i = 0;
  logic            ack_o, irq_o, pv_ready_o, mw_valid_o;
  logic [1:0]      prio_o;
  logic [AW-1:0]   pv_addr_o, mw_addr_o;
  logic [DW-1:0]   pv_data = DBASE, mw_data_o;
  logic            mw_ready = 1'b1;

  dma_chan u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cfg_sel_i(cfg_sel),
    .cfg_pinc_i(cfg_pinc), .cfg_minc_i(cfg_minc), .cfg_pfix4_i(cfg_pfix4),
    .cfg_prio_i(cfg_prio), .cfg_thr_i(cfg_thr), .cfg_direct_i(cfg_direct),
    .cfg_altack_i(cfg_alt), .cfg_count_i(cfg_count), .cfg_pbase_i(cfg_pbase),
    .cfg_mbase_i(cfg_mbase), .req_i(req_i), .ack_o(ack_o), .prio_o(prio_o),
    .irq_o(irq_o), .pv_addr_o(pv_addr_o), .pv_valid_i(1'b1), .pv_ready_o(pv_ready_o),
    .pv_data_i(pv_data), .mw_valid_o(mw_valid_o), .mw_ready_i(mw_ready),
    .mw_addr_o(mw_addr_o), .mw_data_o(mw_data_o)
  );

  int checks = 0, fails = 0;
  int pf, mf, first_mw_pf, irq_cnt, direct_bad;
  bit pend_p, auto_req, chk_direct;
  int asel;
  logic [AW-1:0] plog [64];
  logic [AW-1:0] maddr_log [64];
  logic [DW-1:0] mdata_log [64];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor: handshakes seen here complete on the next rising edge.
  always @(negedge clk) begin
    if (pend_p) begin pv_data = pv_data + 1; pend_p = 0; end
    if (mw_valid_o && first_mw_pf < 0) first_mw_pf = pf;
    if (mw_valid_o && mw_ready) begin
      if (chk_direct && pf != mf + 1) direct_bad++;
      if (mf < 64) begin maddr_log[mf] = mw_addr_o; mdata_log[mf] = mw_data_o; end
      mf++;
    end
    if (pv_ready_o) begin
      if (pf < 64) plog[pf] = pv_addr_o;
      pf++;
      pend_p = 1;
    end
    if (irq_o) irq_cnt++;
    if (auto_req) begin req_i = '0; req_i[asel] = !ack_o; end
  end

  task automatic launch(input int sel, input bit pinc, input bit minc, input bit pfix4,
                        input int prio, input int thr, input bit direct, input bit alt,
                        input int count, input logic [AW-1:0] pb, input logic [AW-1:0] mb);
    @(negedge clk);
    pf = 0; mf = 0; first_mw_pf = -1; irq_cnt = 0; direct_bad = 0;
    pv_data = DBASE; asel = sel;
    cfg_sel = 3'(sel); cfg_pinc = pinc; cfg_minc = minc; cfg_pfix4 = pfix4;
    cfg_prio = 2'(prio); cfg_thr = 2'(thr); cfg_direct = direct; cfg_alt = alt;
    cfg_count = CW'(count); cfg_pbase = pb; cfg_mbase = mb;
    start_i = 1;
    @(negedge clk);
    start_i = 0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (irq_cnt == 0 && n < 2000) begin @(negedge clk); n++; end
    check(irq_cnt == 1, req, "completion pulse seen", irq_cnt, 1);
    check(prio_o == 2'd0, req, "idle at completion (prio 0)", prio_o, 0);
    @(negedge clk);
    check(irq_o == 1'b0, req, "irq lasts one cycle", irq_o, 0);
    auto_req = 0; req_i = '0;
  endtask

  task automatic check_stream(input string req, input int count, input logic [AW-1:0] pb,
                              input int pstep, input logic [AW-1:0] mb, input int mstep);
    int bad_p = 0, bad_m = 0, bad_d = 0;
    check(pf == count, req, "peripheral items read", pf, count);
    check(mf == count, "R10", "memory items written", mf, count);
    for (int i = 0; i < count && i < 64; i++) begin
      if (plog[i] != pb + AW'(pstep * i)) bad_p++;
      if (maddr_log[i] != mb + AW'(mstep * i)) bad_m++;
      if (mdata_log[i] != DBASE + DW'(i)) bad_d++;
    end
    check(bad_p == 0, "R3", "peripheral address sequence", bad_p, 0);
    check(bad_m == 0, "R4", "memory address sequence", bad_m, 0);
    check(bad_d == 0, "R10", "data order preserved", bad_d, 0);
  endtask

  task automatic t_reset();
    check(ack_o == 0 && pv_ready_o == 0, "R12", "ack/ready low after reset", ack_o, 0);
    check(mw_valid_o == 0, "R12", "no write after reset", mw_valid_o, 0);
    check(irq_o == 0 && prio_o == 0, "R5", "irq and prio low after reset", prio_o, 0);
  endtask

  task automatic t_fifo_flush();
    launch(1, 1, 1, 0, 2, 1, 0, 0, 10, 32'h4000_0000, 32'h2000_0000);
    check(prio_o == 2'd2, "R5", "priority code driven while busy", prio_o, 2);
    auto_req = 1;
    wait_done("R11");
    check(first_mw_pf == 4, "R6", "half-full level before first write", first_mw_pf, 4);
    check_stream("R1", 10, 32'h4000_0000, 2, 32'h2000_0000, 4);
  endtask

  task automatic t_fixed_full();
    launch(2, 0, 0, 1, 3, 3, 0, 0, 8, 32'h4000_0100, 32'h2000_0100);
    auto_req = 1;
    wait_done("R11");
    check(first_mw_pf == 8, "R6", "full level before first write", first_mw_pf, 8);
    check_stream("R3", 8, 32'h4000_0100, 0, 32'h2000_0100, 0);
  endtask

  task automatic t_step4();
    launch(7, 1, 1, 1, 0, 0, 0, 0, 5, 32'h4000_0200, 32'h2000_0200);
    auto_req = 1;
    wait_done("R11");
    check(first_mw_pf == 2, "R6", "quarter level before first write", first_mw_pf, 2);
    check_stream("R3", 5, 32'h4000_0200, 4, 32'h2000_0200, 4);
  endtask

  task automatic t_direct();
    chk_direct = 1;
    launch(4, 1, 1, 0, 1, 3, 1, 0, 3, 32'h4000_0300, 32'h2000_0300);
    auto_req = 1;
    wait_done("R11");
    chk_direct = 0;
    check(direct_bad == 0, "R7", "write precedes next read", direct_bad, 0);
    check(first_mw_pf == 1, "R7", "no level wait in direct mode", first_mw_pf, 1);
    check_stream("R7", 3, 32'h4000_0300, 2, 32'h2000_0300, 4);
  endtask

  task automatic t_sel_std_ack();
    launch(5, 0, 0, 0, 0, 0, 0, 0, 1, 32'h4000_0400, 32'h2000_0400);
    req_i = 8'b0000_0100;
    repeat (8) @(negedge clk);
    check(ack_o == 0, "R2", "unselected line ignored", ack_o, 0);
    req_i = 8'b0010_0000;
    @(negedge clk);
    check(ack_o == 1, "R2", "selected line acknowledged", ack_o, 1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(ack_o == 1, "R8", "ack held while request high", ack_o, 1);
    end
    req_i = '0;
    @(negedge clk);
    check(ack_o == 0, "R8", "ack drops after request removed", ack_o, 0);
    wait_done("R11");
  endtask

  task automatic t_alt_ack();
    int n = 0;
    launch(3, 0, 0, 0, 0, 0, 0, 1, 2, 32'h4000_0500, 32'h2000_0500);
    req_i = 8'b0000_1000;
    while (!pv_ready_o && n < 20) begin @(negedge clk); n++; end
    @(negedge clk);
    check(ack_o == 0 && req_i[3] == 1, "R9", "ack drops with request still high", ack_o, 0);
    wait_done("R9");
    check(pf == 2 && mf == 2, "R9", "both items moved", mf, 2);
  endtask

  task automatic t_cfg_ignore();
    launch(6, 1, 0, 0, 1, 0, 0, 0, 4, 32'h4000_0600, 32'h2000_0600);
    repeat (3) @(negedge clk);
    check(prio_o == 2'd1, "R1", "captured priority", prio_o, 1);
    cfg_prio = 3; cfg_count = 9; cfg_pbase = 32'h5555_0000; cfg_sel = 0;
    start_i = 1; @(negedge clk); start_i = 0; @(negedge clk);
    check(prio_o == 2'd1, "R1", "priority unchanged by live edits", prio_o, 1);
    auto_req = 1;
    wait_done("R1");
    check_stream("R1", 4, 32'h4000_0600, 2, 32'h2000_0600, 0);
    launch(0, 0, 0, 0, 3, 0, 0, 0, 0, 0, 0);
    repeat (2) @(negedge clk);
    check(prio_o == 2'd0, "R1", "zero count leaves engine idle", prio_o, 0);
  endtask

  task automatic t_backpressure();
    logic [AW-1:0] a0;
    int n = 0;
    bit held = 1;
    mw_ready = 0;
    launch(1, 1, 1, 0, 2, 0, 0, 0, 4, 32'h4000_0700, 32'h2000_0700);
    auto_req = 1;
    while (!mw_valid_o && n < 50) begin @(negedge clk); n++; end
    a0 = mw_addr_o;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (!mw_valid_o || mw_addr_o != a0) held = 0;
    end
    check(held, "R12", "write held under back-pressure", mw_addr_o, a0);
    mw_ready = 1;
    wait_done("R12");
    check_stream("R12", 4, 32'h4000_0700, 2, 32'h2000_0700, 4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    pend_p = 0; auto_req = 0; chk_direct = 0; asel = 0;
    pf = 0; mf = 0; first_mw_pf = -1; irq_cnt = 0; direct_bad = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fifo_flush();
    t_fixed_full();
    t_step4();
    t_direct();
    t_sel_std_ack();
    t_alt_ack();
    t_cfg_ignore();
    t_backpressure();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule